// File: doc/BRIEF.md
# SpaceWire character receiver

This block turns a stream of already recovered serial bits into SpaceWire characters. Each clock it may take a fixed-size chunk of bits, from one to four as set by a parameter, qualified by a valid flag. It finds character boundaries, checks odd parity, and decodes control codes and escape sequences. It also watches a separate bit-activity input for a disconnect timeout.

Results go to a link controller. Data bytes and end-of-packet markers appear as a flag plus a byte. Flow-control tokens and NULLs appear as single-cycle pulses. A time code appears as a single-cycle pulse, and its control and counter fields stay on the outputs until the next time code. Parity errors, escape errors and disconnects are reported as single-cycle pulses.

The controller enables the block with `rx_en`. Dropping `rx_en` clears all decoding state. Nothing is reported until a NULL has been seen after enable. After the first error the block falls silent until it is disabled and enabled again.

Top module: `spwrx_receiver`

## Requirements
- R1: Bits are consumed in chunk order: `bits_in[0]` first, then `bits_in[1]`, and so on. A character starts with a parity bit followed by a flag bit. Flag 0 marks a data character, which carries 8 more bits least significant first and is output as `char_flag`=0 with the byte on `char_data`.
- R2: Flag 1 marks a control character, which carries 2 more bits forming the code {first, second}. Code 00 is FCT, 01 is EOP, 10 is EEP and 11 is ESC. EOP is output as `char_flag`=1 with `char_data`=0x00, and EEP as `char_flag`=1 with `char_data`=0x01.
- R3: An FCT that does not follow an ESC gives a one-cycle `fct_pulse`.
- R4: ESC followed by FCT gives a one-cycle `null_pulse`. ESC followed by a data character gives a one-cycle `tick_pulse`, with `tick_ctrl` set to data bits 7:6 and `tick_time` set to bits 5:0. Both fields keep their value until the next time code.
- R5: After enable, no character, FCT, time code or error of any kind is reported until the first NULL has been received.
- R6: The data bits of the previous character (8 for data, 2 for control), plus the parity bit and flag bit of the current character, must hold an odd number of ones. Otherwise `err_par` pulses once, when the flag bit is consumed.
- R7: ESC followed by EOP, EEP or ESC pulses `err_esc` once.
- R8: Once a NULL has been seen, `err_disc` pulses in the cycle after the Nth consecutive clock edge with `act` low. N is 850 ns in system clocks, rounded up (43 at 50 MHz).
- R9: While `rx_en` is low, input bits are ignored and nothing is reported. After any error, nothing further is reported until `rx_en` has been low.
- R10: Every result is registered and appears one cycle after the clock edge that consumes the last bit causing it. At most one of character, time code, FCT and NULL is reported in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable from the link controller |
| bit_valid | input | 1 | All CHUNK bits of `bits_in` are valid this cycle |
| bits_in | input | CHUNK | Received bits, index 0 earliest |
| act | input | 1 | Bit activity seen on the line this cycle |
| char_valid | output | 1 | N-Char present for one cycle |
| char_flag | output | 1 | 0 data byte, 1 end-of-packet marker |
| char_data | output | 8 | Data byte, or 0x00 EOP / 0x01 EEP |
| tick_pulse | output | 1 | Time code received |
| tick_ctrl | output | 2 | Control field of the last time code |
| tick_time | output | 6 | Counter field of the last time code |
| fct_pulse | output | 1 | Flow-control token received |
| null_pulse | output | 1 | NULL received |
| err_par | output | 1 | Parity error |
| err_esc | output | 1 | Illegal escape sequence |
| err_disc | output | 1 | Disconnect timeout |

## Verification
Character, time code, FCT, NULL and escape-error pulses are due one cycle after the edge that consumes the character's last bit. A parity error is due one cycle after the edge that consumes the flag bit. Because chunk alignment moves that edge around, the bench keeps an ordered list of expected results and compares each pulse to its head when sampling on the falling edge. Any pulse with nothing expected, and any expected result left over at a checkpoint, is a failure. The disconnect pulse is timed exactly: the bench counts idle edges from the falling edge where `act` drops and requires the pulse after edge 43, not 42.

// File: rtl/spwrx_pkg.sv
`timescale 1ns/1ps
package spwrx_pkg;

    localparam logic [1:0] CODE_FCT = 2'b00;
    localparam logic [1:0] CODE_EOP = 2'b01;
    localparam logic [1:0] CODE_EEP = 2'b10;
    localparam logic [1:0] CODE_ESC = 2'b11;

    // Decoder state carried from bit to bit and from cycle to cycle.
    typedef struct packed {
        logic [3:0] pos;       // bit index inside the current character
        logic       par_bit;   // parity bit of the current character
        logic       flag;      // flag bit of the current character
        logic       run_par;   // xor of data bits collected so far
        logic       prev_par;  // xor of data bits of the previous character
        logic [7:0] sh;        // payload shift register, LSB first
        logic       esc;       // ESC received, follower pending
        logic       null_seen; // first NULL received since enable
        logic       halted;    // error reported, silent until disabled
    } dec_state_t;

    // Results of one bit step.
    typedef struct packed {
        logic       chr;
        logic       chr_flag;
        logic [7:0] chr_data;
        logic       tick;
        logic [7:0] tick_val;
        logic       fct;
        logic       nul;
        logic       epar;
        logic       eesc;
    } dec_evt_t;

    typedef struct packed {
        dec_state_t dec;
        logic       chr_v;
        logic       chr_f;
        logic [7:0] chr_d;
        logic       tick;
        logic [1:0] tctl;
        logic [5:0] ttim;
        logic       fct;
        logic       nul;
        logic       epar;
        logic       eesc;
        logic       edisc;
    } rx_regs_t;

    // 850 ns in clocks of the given frequency, rounded up, at least 1.
    function automatic int disc_clocks(input longint hz);
        longint c;
        c = (hz * 64'd85 + 64'd99_999_999) / 64'd100_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/spwrx_char_classify.sv
`timescale 1ns/1ps
module spwrx_char_classify
    import spwrx_pkg::*;
(
    input  logic       is_ctl,
    input  logic [7:0] sh,
    input  logic       esc_i,
    input  logic       synced_i,
    output dec_evt_t   ev_o,
    output logic       esc_o,
    output logic       synced_o,
    output logic       halt_o
);
    logic [1:0] code;

    always_comb begin
        code     = {sh[6], sh[7]};
        ev_o     = '0;
        esc_o    = esc_i;
        synced_o = synced_i;
        halt_o   = 1'b0;
        if (is_ctl) begin
            if (code == CODE_FCT) begin
                if (esc_i) begin
                    ev_o.nul = 1'b1;
                    synced_o = 1'b1;
                    esc_o    = 1'b0;
                end else begin
                    ev_o.fct = synced_i;
                end
            end else if (code == CODE_ESC) begin
                if (esc_i && synced_i) begin
                    ev_o.eesc = 1'b1;
                    halt_o    = 1'b1;
                    esc_o     = 1'b0;
                end else begin
                    esc_o = 1'b1;
                end
            end else begin
                if (esc_i) begin
                    ev_o.eesc = synced_i;
                    halt_o    = synced_i;
                    esc_o     = 1'b0;
                end else begin
                    ev_o.chr      = synced_i;
                    ev_o.chr_flag = 1'b1;
                    ev_o.chr_data = {7'd0, code == CODE_EEP};
                end
            end
        end else begin
            if (esc_i) begin
                ev_o.tick     = synced_i;
                ev_o.tick_val = sh;
                esc_o         = 1'b0;
            end else begin
                ev_o.chr      = synced_i;
                ev_o.chr_flag = 1'b0;
                ev_o.chr_data = sh;
            end
        end
    end
endmodule

// File: rtl/spwrx_bit_step.sv
`timescale 1ns/1ps
module spwrx_bit_step
    import spwrx_pkg::*;
(
    input  dec_state_t st_i,
    input  logic       bit_i,
    input  logic       en_i,
    output dec_state_t st_o,
    output dec_evt_t   ev_o
);
    logic [7:0] sh_n;
    logic       last;
    dec_evt_t   cls_ev;
    logic       cls_esc;
    logic       cls_sync;
    logic       cls_halt;

    assign sh_n = {bit_i, st_i.sh[7:1]};

    spwrx_char_classify u_cls (
        .is_ctl   (st_i.flag),
        .sh       (sh_n),
        .esc_i    (st_i.esc),
        .synced_i (st_i.null_seen),
        .ev_o     (cls_ev),
        .esc_o    (cls_esc),
        .synced_o (cls_sync),
        .halt_o   (cls_halt)
    );

    always_comb begin
        st_o = st_i;
        ev_o = '0;
        last = 1'b0;
        if (en_i && !st_i.halted) begin
            if (st_i.pos == 4'd0) begin
                st_o.par_bit = bit_i;
                st_o.pos     = 4'd1;
            end else if (st_i.pos == 4'd1) begin
                st_o.flag    = bit_i;
                st_o.run_par = 1'b0;
                st_o.sh      = '0;
                st_o.pos     = 4'd2;
                if (st_i.null_seen && !(st_i.prev_par ^ st_i.par_bit ^ bit_i)) begin
                    ev_o.epar   = 1'b1;
                    st_o.halted = 1'b1;
                end
            end else begin
                st_o.sh      = sh_n;
                st_o.run_par = st_i.run_par ^ bit_i;
                last = st_i.flag ? (st_i.pos == 4'd3) : (st_i.pos == 4'd9);
                if (last) begin
                    st_o.pos       = 4'd0;
                    st_o.prev_par  = st_i.run_par ^ bit_i;
                    ev_o           = cls_ev;
                    st_o.esc       = cls_esc;
                    st_o.null_seen = cls_sync;
                    st_o.halted    = cls_halt;
                end else begin
                    st_o.pos = st_i.pos + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/spwrx_disc_timer.sv
`timescale 1ns/1ps
module spwrx_disc_timer #(
    parameter int LIMIT = 43
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic act_i,
    output logic expired_o
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || act_i)
            cnt_d = '0;
        else if (cnt_q != W'(LIMIT))
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired_o = en_i && !act_i && (cnt_q == W'(LIMIT - 1));

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && act_i) |=> (cnt_q == '0));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= W'(LIMIT));
endmodule

// File: rtl/spwrx_receiver.sv
`timescale 1ns/1ps
module spwrx_receiver
    import spwrx_pkg::*;
#(
    parameter int     CHUNK  = 1,
    parameter longint SYS_HZ = 50_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             bit_valid,
    input  logic [CHUNK-1:0] bits_in,
    input  logic             act,
    output logic             char_valid,
    output logic             char_flag,
    output logic [7:0]       char_data,
    output logic             tick_pulse,
    output logic [1:0]       tick_ctrl,
    output logic [5:0]       tick_time,
    output logic             fct_pulse,
    output logic             null_pulse,
    output logic             err_par,
    output logic             err_esc,
    output logic             err_disc
);
    localparam int DISC_CLKS = disc_clocks(SYS_HZ);

    rx_regs_t   r_d, r_q;
    dec_state_t chain [CHUNK+1];
    dec_evt_t   evs   [CHUNK];
    dec_evt_t   m;
    logic       expired;
    logic       fire;
    logic       step_en;

    assign chain[0] = r_q.dec;
    assign step_en  = rx_en && bit_valid;

    for (genvar g = 0; g < CHUNK; g++) begin : g_step
        spwrx_bit_step u_step (
            .st_i  (chain[g]),
            .bit_i (bits_in[g]),
            .en_i  (step_en),
            .st_o  (chain[g+1]),
            .ev_o  (evs[g])
        );
    end

    spwrx_disc_timer #(.LIMIT(DISC_CLKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .en_i      (rx_en),
        .act_i     (act),
        .expired_o (expired)
    );

    always_comb begin
        m = '0;
        for (int g = 0; g < CHUNK; g++)
            m = m | evs[g];
        fire = expired && r_q.dec.null_seen && !r_q.dec.halted;

        r_d     = r_q;
        r_d.dec = rx_en ? chain[CHUNK] : '0;
        if (fire)
            r_d.dec.halted = 1'b1;
        r_d.chr_v = m.chr;
        if (m.chr) begin
            r_d.chr_f = m.chr_flag;
            r_d.chr_d = m.chr_data;
        end
        r_d.tick = m.tick;
        if (m.tick) begin
            r_d.tctl = m.tick_val[7:6];
            r_d.ttim = m.tick_val[5:0];
        end
        r_d.fct   = m.fct;
        r_d.nul   = m.nul;
        r_d.epar  = m.epar;
        r_d.eesc  = m.eesc;
        r_d.edisc = fire;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign char_valid = r_q.chr_v;
    assign char_flag  = r_q.chr_f;
    assign char_data  = r_q.chr_d;
    assign tick_pulse = r_q.tick;
    assign tick_ctrl  = r_q.tctl;
    assign tick_time  = r_q.ttim;
    assign fct_pulse  = r_q.fct;
    assign null_pulse = r_q.nul;
    assign err_par    = r_q.epar;
    assign err_esc    = r_q.eesc;
    assign err_disc   = r_q.edisc;

    // R10
    single_result_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({r_q.chr_v, r_q.tick, r_q.fct, r_q.nul}));

    // R5
    sync_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.chr_v || r_q.tick || r_q.fct || r_q.epar || r_q.eesc || r_q.edisc)
        |-> r_q.dec.null_seen);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !(r_q.chr_v || r_q.tick || r_q.fct || r_q.nul ||
                     r_q.epar || r_q.eesc || r_q.edisc));

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.dec.halted |=> !(r_q.chr_v || r_q.tick || r_q.fct || r_q.nul ||
                             r_q.epar || r_q.eesc || r_q.edisc));

    // R4
    tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !r_q.tick |-> $stable({r_q.tctl, r_q.ttim}));
endmodule

// File: tb/sim_spwrx_receiver.sv
`timescale 1ns/1ps
module sim_spwrx_receiver;
    localparam int CH       = 3;
    localparam int EXP_DISC = 43;   // 850 ns / 20 ns, rounded up
    localparam int K_DATA = 1, K_CTRL = 2, K_TICK = 3, K_FCT = 4,
                   K_NULL = 5, K_PAR = 6, K_ESC = 7, K_DISC = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_en = 1'b0;
    logic          bit_valid = 1'b0;
    logic          act = 1'b1;
    logic [CH-1:0] bits_in = '0;
    logic          char_valid, char_flag, tick_pulse, fct_pulse, null_pulse;
    logic          err_par, err_esc, err_disc;
    logic [7:0]    char_data;
    logic [1:0]    tick_ctrl;
    logic [5:0]    tick_time;

    always #10 clk = ~clk;

    spwrx_receiver #(.CHUNK(CH), .SYS_HZ(50_000_000)) u0 (
        .clk(clk), .rst(rst), .rx_en(rx_en), .bit_valid(bit_valid),
        .bits_in(bits_in), .act(act), .char_valid(char_valid),
        .char_flag(char_flag), .char_data(char_data), .tick_pulse(tick_pulse),
        .tick_ctrl(tick_ctrl), .tick_time(tick_time), .fct_pulse(fct_pulse),
        .null_pulse(null_pulse), .err_par(err_par), .err_esc(err_esc),
        .err_disc(err_disc)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    bit          bitq[$];
    logic [11:0] exq[$];
    bit          prevpar = 0;

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic string req_of(input int k);
        case (k)
            K_DATA: return "R1";
            K_CTRL: return "R2";
            K_TICK: return "R4";
            K_FCT:  return "R3";
            K_NULL: return "R4";
            K_PAR:  return "R6";
            K_ESC:  return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic expect_ev(input int k, input logic [7:0] v);
        exq.push_back({k[3:0], v});
    endtask

    task automatic seen(input int k, input logic [7:0] v);
        logic [11:0] got, exp;
        got = {k[3:0], v};
        if (exq.size() == 0) begin
            check(0, req_of(k), int'(got), 0);
        end else begin
            exp = exq.pop_front();
            check(got == exp, req_of(k), int'(got), int'(exp));
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (char_valid) seen(char_flag ? K_CTRL : K_DATA, char_data);
            if (tick_pulse) seen(K_TICK, {tick_ctrl, tick_time});
            if (fct_pulse)  seen(K_FCT, 8'h00);
            if (null_pulse) seen(K_NULL, 8'h00);
            if (err_par)    seen(K_PAR, 8'h00);
            if (err_esc)    seen(K_ESC, 8'h00);
            if (err_disc)   seen(K_DISC, 8'h00);
        end
    end

    // Serialise one character: parity, flag, then n payload bits LSB first.
    task automatic put_char(input bit f, input bit [7:0] v, input bit badpar);
        int n;
        bit np;
        n  = f ? 2 : 8;
        np = 0;
        bitq.push_back(~(prevpar ^ f) ^ badpar);
        bitq.push_back(f);
        for (int i = 0; i < n; i++) begin
            bitq.push_back(v[i]);
            np ^= v[i];
        end
        prevpar = np;
    endtask

    // code is {first, second}
    task automatic put_ctl(input bit [1:0] code);
        put_char(1'b1, {6'd0, code[0], code[1]}, 1'b0);
    endtask

    task automatic put_null(input bit ex);
        put_ctl(2'b11);
        put_ctl(2'b00);
        if (ex) expect_ev(K_NULL, 8'h00);
    endtask

    task automatic pad_nulls(input bit ex);
        while (bitq.size() % CH != 0) put_null(ex);
    endtask

    task automatic flush();
        while (bitq.size() >= CH) begin
            @(negedge clk);
            for (int i = 0; i < CH; i++) bits_in[i] = bitq.pop_front();
            bit_valid = 1'b1;
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic drained(input string req);
        repeat (3) @(negedge clk);
        check(exq.size() == 0, req, exq.size(), 0);
    endtask

    task automatic restart();
        bitq.delete();
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); rx_en = 1'b1;
        prevpar = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R10 watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int got;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check({char_valid, tick_pulse, fct_pulse, null_pulse} == 4'b0, "R10 reset pulses",
              {char_valid, tick_pulse, fct_pulse, null_pulse}, 0);
        check({err_par, err_esc, err_disc} == 3'b0, "R9 reset errors",
              {err_par, err_esc, err_disc}, 0);
        check({tick_ctrl, tick_time} == 8'h00, "R4 reset tick fields",
              {tick_ctrl, tick_time}, 0);

        // R9: bits while disabled are ignored
        put_null(0); put_char(0, 8'hA5, 0); pad_nulls(0);
        flush();
        drained("R9 disabled");

        // R5: nothing before the first NULL, including a long idle
        restart();
        act = 1'b0;
        repeat (60) @(negedge clk);
        act = 1'b1;
        put_ctl(2'b00);
        put_char(0, 8'h5A, 0);
        put_ctl(2'b01);
        put_ctl(2'b11); put_ctl(2'b01);
        put_char(0, 8'h33, 1);
        put_null(1);
        pad_nulls(1);
        flush();
        drained("R5 pre-sync");

        // R3, R2, R1, R4 main decoding
        put_ctl(2'b00); expect_ev(K_FCT, 8'h00);
        put_ctl(2'b01); expect_ev(K_CTRL, 8'h00);
        put_ctl(2'b10); expect_ev(K_CTRL, 8'h01);
        for (int i = 0; i < 256; i++) begin
            put_char(0, i[7:0], 0);
            expect_ev(K_DATA, i[7:0]);
        end
        for (int i = 0; i < 256; i++) begin
            put_ctl(2'b11);
            put_char(0, i[7:0], 0);
            expect_ev(K_TICK, i[7:0]);
        end
        put_null(1);
        for (int i = 0; i < 3; i++) begin
            put_ctl(2'b00);
            expect_ev(K_FCT, 8'h00);
        end
        pad_nulls(1);
        flush();
        drained("R1 R2 R3 R4 stream");
        // R4: last time code fields held after later characters
        check({tick_ctrl, tick_time} == 8'hFF, "R4 hold",
              {tick_ctrl, tick_time}, 8'hFF);

        // R8: disconnect timeout, exact edge count
        @(negedge clk);
        act = 1'b0;
        expect_ev(K_DISC, 8'h00);
        got = -1;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            if (err_disc && got < 0) got = k;
        end
        check(got == EXP_DISC, "R8 timeout edge", got, EXP_DISC);
        act = 1'b1;
        // R9: silent after error
        put_null(0); put_char(0, 8'h42, 0); put_ctl(2'b00); pad_nulls(0);
        flush();
        drained("R9 after disconnect");

        // R6: parity error on a data character, then silence
        restart();
        put_null(1);
        put_char(0, 8'h11, 1); expect_ev(K_PAR, 8'h00);
        put_ctl(2'b00);
        pad_nulls(0);
        flush();
        drained("R6 data parity");

        // R6: parity error on a control character
        restart();
        put_null(1);
        put_char(0, 8'h80, 0); expect_ev(K_DATA, 8'h80);
        put_char(1, 8'h02, 1); expect_ev(K_PAR, 8'h00);
        pad_nulls(0);
        flush();
        drained("R6 control parity");

        // R7: illegal followers of ESC
        for (int c = 1; c < 4; c++) begin
            restart();
            put_null(1);
            put_ctl(2'b11);
            put_ctl(c[1:0]); expect_ev(K_ESC, 8'h00);
            put_ctl(2'b00);
            pad_nulls(0);
            flush();
            drained("R7 escape");
        end

        finish_run();
    end
endmodule